// File: doc/BRIEF.md
# Single-Bunch Measure, Multi-Bunch Kick Feedback Controller

This block is the digital core of a fast position feedback loop for a short train of particle bunches. A train trigger starts a per-train cycle counter. After a programmable delay the block captures one sample of the difference and sum channels of a position monitor, which together describe the first bunch. It then derives a normalised position with a bit-serial divider and turns it into a kicker drive code. The code stays on the DAC output until a programmable end-of-train count and is then removed, so it reaches the later bunches of the same train but never the next train.

The whole chain, from the capture edge to the DAC update, must fit inside one bunch spacing (about 61 cycles at the beam-locked clock). The block measures this latency on every train and flags it against a configured budget. Per-train status (missing beam, latency, late flag) is cleared by the trigger and latched when the correction is produced.

Top module: `bunch_fb_ctrl`

## Requirements
- R1: After reset, `dac_code_o`, `pos_o`, `nobeam_o`, `late_o` and `latency_o` are all zero.
- R2: A trigger is accepted only while no train is in progress. A trigger pulse during a train changes neither the capture timing nor the DAC timing of that train.
- R3: Counting the trigger edge as edge 0, the block captures `adc_diff_i` and `adc_sum_i` at rising edge `cfg_delay_i`+1. Values presented at any other edge have no effect.
- R4: The reported position `pos_o` is the signed quotient diff*256/sum, truncated toward zero. It is 22 bits wide.
- R5: The correction is -floor((pos - `cfg_offset_i`) * `cfg_gain_i` / 256), with signed offset and gain.
- R6: The correction saturates to the 14-bit signed DAC range [-8192, 8191] and never wraps.
- R7: The DAC code and the latched status update exactly 23 cycles after the capture edge (number of quotient bits + 1), and `latency_o` reports 23.
- R8: The DAC code is held until rising edge `cfg_end_i`+1 after the trigger edge, where it returns to zero. It is zero whenever no train is in progress.
- R9: If the captured sum is not positive or is below `cfg_sum_min_i`, the DAC code stays zero, `nobeam_o` is set and `pos_o` is zero.
- R10: With `cfg_enable_i` low, `pos_o` is still updated but the DAC code stays zero.
- R11: `late_o` is set exactly when the measured latency is greater than `cfg_budget_i`.
- R12: `nobeam_o`, `late_o` and `latency_o` are cleared at the trigger edge that starts a train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-locked processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Train-start trigger, sampled at the rising edge |
| adc_diff_i | input | 14 | Signed difference-channel sample |
| adc_sum_i | input | 14 | Signed sum-channel sample |
| cfg_enable_i | input | 1 | Loop enable; when low the DAC output stays zero |
| cfg_gain_i | input | 16 | Signed loop gain, 8 fraction bits |
| cfg_offset_i | input | 22 | Signed position setpoint |
| cfg_delay_i | input | 8 | Trigger-to-capture count |
| cfg_end_i | input | 8 | Trigger-to-release count (end of train) |
| cfg_sum_min_i | input | 14 | Minimum sum treated as beam present |
| cfg_budget_i | input | 8 | Allowed capture-to-DAC latency in cycles |
| dac_code_o | output | 14 | Signed kicker drive code |
| pos_o | output | 22 | Signed measured position of the first bunch |
| nobeam_o | output | 1 | Latched: no beam in the last train |
| late_o | output | 1 | Latched: latency exceeded the budget |
| latency_o | output | 8 | Latched capture-to-DAC latency in cycles |

## Verification
The hardest property to show from the ports is that only one edge of the ADC stream counts. The bench drives deliberately wrong diff and sum values on every edge except the capture edge, so any shift in the capture point corrupts the position. A second trigger pulse is injected in the middle of a train to show that the capture and release edges do not move. Saturation in both signs is reached with tiny sum values and the largest gain. The late flag is tested with the budget set to exactly the latency and then one cycle below it.

// File: rtl/bfb_pkg.sv
`timescale 1ns/1ps
package bfb_pkg;
  parameter int ADC_W   = 14;
  parameter int FRAC_W  = 8;
  parameter int GAIN_W  = 16;
  parameter int GAIN_SH = 8;
  parameter int DAC_W   = 14;
  parameter int CNT_W   = 8;

  localparam int QUO_W   = ADC_W + FRAC_W;
  localparam int POS_W   = QUO_W;
  localparam int PROD_W  = POS_W + 1 + GAIN_W;
  localparam int DAC_MAX = (2 ** (DAC_W - 1)) - 1;
  localparam int DAC_MIN = -(2 ** (DAC_W - 1));

  function automatic logic [ADC_W-1:0] mag_of(input logic signed [ADC_W-1:0] v);
    logic signed [ADC_W:0] w;
    w = {v[ADC_W-1], v};
    if (v[ADC_W-1]) w = -w;
    return w[ADC_W-1:0];
  endfunction

  function automatic logic signed [POS_W-1:0] pos_from_quot(input logic neg,
                                                           input logic [QUO_W-1:0] q);
    logic signed [POS_W-1:0] p;
    p = signed'(q);
    return neg ? -p : p;
  endfunction

  function automatic logic signed [DAC_W-1:0] kick_from_pos(
      input logic signed [POS_W-1:0] pos,
      input logic signed [POS_W-1:0] off,
      input logic signed [GAIN_W-1:0] gain);
    logic signed [POS_W:0]    err;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W:0]   neg;
    err  = {pos[POS_W-1], pos} - {off[POS_W-1], off};
    prod = PROD_W'(err) * PROD_W'(gain);
    neg  = -((PROD_W + 1)'(prod >>> GAIN_SH));
    if (neg > (PROD_W + 1)'(DAC_MAX)) return DAC_W'(DAC_MAX);
    if (neg < (PROD_W + 1)'(DAC_MIN)) return DAC_W'(DAC_MIN);
    return neg[DAC_W-1:0];
  endfunction
endpackage

// File: rtl/pos_divider.sv
`timescale 1ns/1ps
module pos_divider #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic              active;
  logic [STEP_W-1:0] step;
  logic [NUM_W-1:0]  dvd;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    sub;
  logic              fits;

  assign trial  = {rem, dvd[NUM_W-1]};
  assign sub    = trial - {1'b0, den_q};
  assign fits   = trial >= {1'b0, den_q};
  assign done_o = active && (step == STEP_W'(NUM_W));
  assign busy_o = active;
  assign quot_o = dvd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      dvd    <= '0;
      rem    <= '0;
      den_q  <= '0;
    end else if (abort_i) begin
      active <= 1'b0;
    end else if (start_i) begin
      active <= 1'b1;
      step   <= '0;
      dvd    <= num_i;
      rem    <= '0;
      den_q  <= den_i;
    end else if (done_o) begin
      active <= 1'b0;
    end else if (active) begin
      rem  <= fits ? sub[DEN_W-1:0] : trial[DEN_W-1:0];
      dvd  <= {dvd[NUM_W-2:0], fits};
      step <= step + 1'b1;
    end
  end

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !busy_o);
endmodule

// File: rtl/train_seq.sv
`timescale 1ns/1ps
module train_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             run_o,
  output logic             start_o,
  output logic             sample_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt;
  logic             taken;

  assign start_o  = !run_o && trig_i;
  assign sample_o = run_o && !taken && (cnt == delay_i);
  assign end_o    = run_o && (cnt == end_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o <= 1'b0;
      cnt   <= '0;
      taken <= 1'b0;
    end else if (start_o) begin
      run_o <= 1'b1;
      cnt   <= '0;
      taken <= 1'b0;
    end else if (run_o) begin
      if (end_o) run_o <= 1'b0;
      if (sample_o) taken <= 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  // R2
  train_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> run_o);
  // R3
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);
endmodule

// File: rtl/bunch_fb_ctrl.sv
`timescale 1ns/1ps
module bunch_fb_ctrl
  import bfb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_i,
  input  logic signed [ADC_W-1:0]  adc_diff_i,
  input  logic signed [ADC_W-1:0]  adc_sum_i,
  input  logic                     cfg_enable_i,
  input  logic signed [GAIN_W-1:0] cfg_gain_i,
  input  logic signed [POS_W-1:0]  cfg_offset_i,
  input  logic [CNT_W-1:0]         cfg_delay_i,
  input  logic [CNT_W-1:0]         cfg_end_i,
  input  logic [ADC_W-1:0]         cfg_sum_min_i,
  input  logic [CNT_W-1:0]         cfg_budget_i,
  output logic signed [DAC_W-1:0]  dac_code_o,
  output logic signed [POS_W-1:0]  pos_o,
  output logic                     nobeam_o,
  output logic                     late_o,
  output logic [CNT_W-1:0]         latency_o
);
  logic             run, train_start, sample_stb, train_end;
  logic             div_busy, div_done;
  logic [QUO_W-1:0] quot;
  logic             beam_now, beam_q, neg_q;
  logic [CNT_W-1:0] lat_q, lat_next;
  logic signed [POS_W-1:0] pos_new;
  logic signed [DAC_W-1:0] kick_new;

  train_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .delay_i(cfg_delay_i), .end_i(cfg_end_i),
    .run_o(run), .start_o(train_start), .sample_o(sample_stb), .end_o(train_end)
  );

  pos_divider #(.NUM_W(QUO_W), .DEN_W(ADC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(sample_stb), .abort_i(train_end),
    .num_i({mag_of(adc_diff_i), {FRAC_W{1'b0}}}), .den_i(adc_sum_i),
    .busy_o(div_busy), .done_o(div_done), .quot_o(quot)
  );

  assign beam_now = !adc_sum_i[ADC_W-1] && (adc_sum_i != '0) &&
                    ($unsigned(adc_sum_i) >= cfg_sum_min_i);
  assign pos_new  = beam_q ? pos_from_quot(neg_q, quot) : '0;
  assign kick_new = kick_from_pos(pos_new, cfg_offset_i, cfg_gain_i);
  assign lat_next = lat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beam_q <= 1'b0;
      neg_q  <= 1'b0;
      lat_q  <= '0;
    end else if (sample_stb) begin
      beam_q <= beam_now;
      neg_q  <= adc_diff_i[ADC_W-1];
      lat_q  <= '0;
    end else if (div_busy && !div_done && lat_q != '1) begin
      lat_q <= lat_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code_o <= '0;
      pos_o      <= '0;
      nobeam_o   <= 1'b0;
      late_o     <= 1'b0;
      latency_o  <= '0;
    end else if (train_start) begin
      nobeam_o  <= 1'b0;
      late_o    <= 1'b0;
      latency_o <= '0;
    end else if (train_end) begin
      dac_code_o <= '0;
    end else if (div_done) begin
      pos_o      <= pos_new;
      nobeam_o   <= !beam_q;
      latency_o  <= lat_next;
      late_o     <= lat_next > cfg_budget_i;
      dac_code_o <= (cfg_enable_i && beam_q) ? kick_new : '0;
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> dac_code_o == '0);
  // R8
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !div_done && !train_end && !train_start |=> $stable(dac_code_o));
  // R9
  nobeam_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nobeam_o |-> dac_code_o == '0);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done && !cfg_enable_i |=> dac_code_o == '0);
  // R12
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> !nobeam_o && !late_o && latency_o == '0);
endmodule

// File: tb/bunch_fb_ctrl_test.sv
`timescale 1ns/1ps
module bunch_fb_ctrl_test;
  localparam int QB  = 22;
  localparam int DLY = 5;
  localparam int ENDC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic signed [13:0] diff = '0, sum = '0;
  logic en = 1'b1;
  logic signed [15:0] gain = '0;
  logic signed [21:0] off = '0;
  logic [7:0] dly = 8'(DLY), endc = 8'(ENDC), budget = 8'd40;
  logic [13:0] smin = 14'd100;
  logic signed [13:0] dac;
  logic signed [21:0] pos;
  logic nob, late;
  logic [7:0] lat;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bunch_fb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .adc_diff_i(diff), .adc_sum_i(sum),
    .cfg_enable_i(en), .cfg_gain_i(gain), .cfg_offset_i(off), .cfg_delay_i(dly),
    .cfg_end_i(endc), .cfg_sum_min_i(smin), .cfg_budget_i(budget),
    .dac_code_o(dac), .pos_o(pos), .nobeam_o(nob), .late_o(late), .latency_o(lat)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_train(input int d, input int s, input bit e, input int g,
                           input int o, input int bud, input bit retrig,
                           input string tag);
    longint p, prod, k_exp;
    bit beam;
    int t_on;
    beam = (s > 0) && (s >= int'(smin));
    p = beam ? (longint'(d) * 256) / s : 0;
    prod = (p - o) * g;
    k_exp = -(prod >>> 8);
    if (k_exp > 8191) k_exp = 8191;
    if (k_exp < -8192) k_exp = -8192;
    if (!beam || !e) k_exp = 0;
    t_on = DLY + QB + 2;
    en = e; gain = 16'(g); off = 22'(o); budget = 8'(bud);
    trig = 1'b1;
    @(posedge clk); #1;
    trig = 1'b0;
    check({tag, " R12 nobeam clear"}, nob, 0);
    check({tag, " R12 late clear"}, late, 0);
    check({tag, " R12 latency clear"}, lat, 0);
    for (int k = 1; k <= ENDC + 4; k++) begin
      if (k == DLY + 1) begin diff = 14'(d); sum = 14'(s); end
      else begin diff = 14'(d + 777); sum = 14'd3000; end
      trig = retrig && (k == 12);
      @(posedge clk); #1;
      trig = 1'b0;
      if (k >= t_on && k <= ENDC)
        check({tag, " R3 R5 R6 R7 dac held"}, dac, k_exp);
      else
        check({tag, " R2 R8 dac zero"}, dac, 0);
      if (k >= t_on) begin
        check({tag, " R4 R9 R10 pos"}, pos, p);
        check({tag, " R9 nobeam"}, nob, !beam);
        check({tag, " R7 latency"}, lat, QB + 1);
        check({tag, " R11 late"}, late, (QB + 1) > bud);
      end else begin
        check({tag, " R12 nobeam low"}, nob, 0);
        check({tag, " R12 late low"}, late, 0);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 dac", dac, 0);
    check("R1 pos", pos, 0);
    check("R1 nobeam", nob, 0);
    check("R1 late", late, 0);
    check("R1 latency", lat, 0);
    repeat (2) @(posedge clk); #1;
    run_train(1000, 4000, 1, 256, 0, 40, 0, "basic");
    run_train(-3000, 2000, 1, -512, 10, 40, 0, "neg gain offset");
    run_train(-8000, 100, 1, 32767, 0, 40, 0, "sat pos R6");
    run_train(8000, 100, 1, 32767, 0, 40, 0, "sat neg R6");
    run_train(500, 50, 1, 256, 0, 40, 0, "below min R9");
    run_train(500, -200, 1, 256, 0, 40, 0, "negative sum R9");
    run_train(2500, 3000, 0, 256, 0, 40, 0, "disabled R10");
    run_train(1200, 1500, 1, 300, -40, 23, 0, "budget equal R11");
    run_train(1200, 1500, 1, 300, -40, 22, 0, "budget short R11");
    run_train(-700, 900, 1, 1000, 5, 40, 1, "retrigger R2");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule